// File: doc/BRIEF.md
# MDIO Management Access Controller

This block gives host software access to the management registers of an Ethernet PHY through two word-wide registers. A command register holds the target PHY address, the register index, a direction bit and a busy flag. A data register holds the 16-bit value to send, or the value that comes back. When the host writes the command register with the busy flag set, the controller sends one 64-bit management frame on the MDC/MDIO pair. When the frame is complete, hardware clears the flag.

MDC is produced from the system clock by an even divider. It runs only while a frame is in flight. The controller changes MDIO only while MDC is low and samples it on MDC rising edges. MDIO is driven through an output enable, and the enable is released for the turnaround and data phase of a read. The PHY integrated alongside the controller answers at address 1. A silent address reads back as all ones from the bus pull-up.

Software polls the busy flag. The data register is only meaningful after busy returns to 0. Any register write made while busy is 1 is dropped.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset, both register read ports return 0x00000000, MDC is low and the MDIO output enable is low.
- R2: Command register field layout:
  - PHY address in bits 15:11.
  - Register index in bits 10:6.
  - Direction in bit 1 (1 = write, 0 = read).
  - Busy in bit 0.
  - Bits 31:16 and 5:2 read as zero.
  Data register field layout:
  - Value in bits 15:0.
  - Bits 31:16 read as zero.
- R3: Writing the command register with bit 0 set while idle starts exactly one frame. Busy then reads 1 from the next cycle until the frame ends, and then reads 0. Writing it with bit 0 clear starts nothing and leaves MDC low.
- R4: Host writes to either register while busy is 1 have no effect on any register field.
- R5: A write frame is 64 bits, sent MSB first, with MDIO driven for all 64:
  - 32 ones.
  - Start 01.
  - Opcode 01.
  - 5-bit PHY address.
  - 5-bit register index.
  - Turnaround 10.
  - The 16 data bits.
- R6: A read frame sends 32 ones, start 01, opcode 10, the PHY address and the register index (46 driven bits). It then releases MDIO for the remaining 18 bits and captures bits 48 to 63 of the frame as data bits 15 to 0. The captured value is in the data register when busy clears.
- R7: MDC has a period of CLK_DIV system clocks with equal high and low phases. It stays low when no frame is active. MDIO output and output enable change only while MDC is low.
- R8: After a frame ends, the output enable is low and MDC stays low until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr_en | input | 1 | Host register write strobe |
| host_sel | input | 1 | Write target: 0 = command register, 1 = data register |
| host_wdata | input | 32 | Host write data |
| acc_rdata | output | 32 | Command register read value |
| data_rdata | output | 32 | Data register read value |
| mdc | output | 1 | Management clock |
| mdio_i | input | 1 | MDIO input from the pad |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |

## Verification
A wrong bit counter or shift register shows at the MDC rising edge of the first bit that is out of place. The bench compares every captured frame bit and the output enable at each rising edge, so the fault is caught within one MDC period. A busy flag that is stuck or clears early changes when software sees the end of the frame: the bench sees a missing or extra MDC edge, or a wrong read value, by the end of that frame. A failure to ignore writes during busy shows up on the read ports as soon as the frame ends.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_LEN   = 64;
  localparam int CNT_W       = 6;
  localparam int DRIVEN_RD   = 46;
  localparam int DATA_FIRST  = 48;
  localparam logic [1:0] SOF      = 2'b01;
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] TA_WRITE = 2'b10;

  typedef struct packed {
    logic [4:0] phy;
    logic [4:0] idx;
    logic       wr;
  } mdio_cmd_t;
endpackage

// File: rtl/mdio_clk_gen.sv
module mdio_clk_gen #(
  parameter int CLK_DIV = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic rise_tick,
  output logic fall_tick
);
  localparam int HALF = CLK_DIV / 2;
  localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          mdc_q, mdc_d;
  logic          tick;

  always_comb begin
    tick  = run && (cnt_q == CW'(HALF - 1));
    cnt_d = cnt_q;
    mdc_d = mdc_q;
    if (!run) begin
      cnt_d = '0;
      mdc_d = 1'b0;
    end else if (tick) begin
      cnt_d = '0;
      mdc_d = ~mdc_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end

  assign mdc       = mdc_q;
  assign rise_tick = tick && !mdc_q;
  assign fall_tick = tick && mdc_q;
endmodule

// File: rtl/mdio_frame_eng.sv
module mdio_frame_eng
  import mdio_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  mdio_cmd_t        cmd,
  input  logic [15:0]      wdata,
  input  logic             rise_tick,
  input  logic             fall_tick,
  input  logic             mdio_i,
  output logic             active,
  output logic             done,
  output logic [15:0]      rdata,
  output logic             mdio_o,
  output logic             mdio_oe
);
  logic                 active_q, active_d;
  logic [CNT_W-1:0]     cnt_q, cnt_d;
  logic [FRAME_LEN-1:0] tx_q, tx_d;
  logic                 wr_q, wr_d;
  logic [15:0]          rx_q, rx_d;
  logic                 last_bit;

  always_comb begin
    active_d = active_q;
    cnt_d    = cnt_q;
    tx_d     = tx_q;
    wr_d     = wr_q;
    rx_d     = rx_q;
    last_bit = (cnt_q == CNT_W'(FRAME_LEN - 1));
    done     = active_q && fall_tick && last_bit;
    if (!active_q) begin
      if (start) begin
        active_d = 1'b1;
        cnt_d    = '0;
        wr_d     = cmd.wr;
        rx_d     = '0;
        if (cmd.wr)
          tx_d = {32'hFFFF_FFFF, SOF, OP_WRITE, cmd.phy, cmd.idx, TA_WRITE, wdata};
        else
          tx_d = {32'hFFFF_FFFF, SOF, OP_READ, cmd.phy, cmd.idx, 18'h3FFFF};
      end
    end else begin
      if (fall_tick) begin
        if (last_bit) begin
          active_d = 1'b0;
        end else begin
          cnt_d = cnt_q + 1'b1;
          tx_d  = {tx_q[FRAME_LEN-2:0], 1'b1};
        end
      end
      if (rise_tick && !wr_q && (cnt_q >= CNT_W'(DATA_FIRST)))
        rx_d = {rx_q[14:0], mdio_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      tx_q     <= '0;
      wr_q     <= 1'b0;
      rx_q     <= '0;
    end else begin
      active_q <= active_d;
      cnt_q    <= cnt_d;
      tx_q     <= tx_d;
      wr_q     <= wr_d;
      rx_q     <= rx_d;
    end
  end

  assign active  = active_q;
  assign rdata   = rx_q;
  assign mdio_o  = active_q && tx_q[FRAME_LEN-1];
  assign mdio_oe = active_q && (wr_q || (cnt_q < CNT_W'(DRIVEN_RD)));
endmodule

// File: rtl/mdio_acc_regs.sv
module mdio_acc_regs
  import mdio_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_wr_en,
  input  logic        host_sel,
  input  logic [31:0] host_wdata,
  input  logic        done,
  input  logic [15:0] rdata,
  output mdio_cmd_t   cmd,
  output mdio_cmd_t   start_cmd,
  output logic        busy,
  output logic [15:0] data,
  output logic        start
);
  mdio_cmd_t   cmd_q, cmd_d;
  logic        busy_q, busy_d;
  logic [15:0] data_q, data_d;
  logic        unused_bits;

  assign unused_bits = ^{host_wdata[31:16], host_wdata[5:2]};

  always_comb begin
    start_cmd.phy = host_wdata[15:11];
    start_cmd.idx = host_wdata[10:6];
    start_cmd.wr  = host_wdata[1];
    start         = host_wr_en && !host_sel && !busy_q && host_wdata[0];
    cmd_d  = cmd_q;
    busy_d = busy_q;
    data_d = data_q;
    if (busy_q) begin
      if (done) begin
        busy_d = 1'b0;
        if (!cmd_q.wr) data_d = rdata;
      end
    end else if (host_wr_en) begin
      if (host_sel) begin
        data_d = host_wdata[15:0];
      end else begin
        cmd_d  = start_cmd;
        busy_d = host_wdata[0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      busy_q <= 1'b0;
      data_q <= '0;
    end else begin
      cmd_q  <= cmd_d;
      busy_q <= busy_d;
      data_q <= data_d;
    end
  end

  assign cmd  = cmd_q;
  assign busy = busy_q;
  assign data = data_q;
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
  import mdio_pkg::*;
#(
  parameter int CLK_DIV = 20
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_wr_en,
  input  logic        host_sel,
  input  logic [31:0] host_wdata,
  output logic [31:0] acc_rdata,
  output logic [31:0] data_rdata,
  output logic        mdc,
  input  logic        mdio_i,
  output logic        mdio_o,
  output logic        mdio_oe
);
  logic [1:0]  rst_sync_q;
  logic        rst_int_n;
  mdio_cmd_t   cmd, start_cmd;
  logic        busy, start, done, active;
  logic [15:0] data, rdata;
  logic        rise_tick, fall_tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  mdio_acc_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .host_wr_en (host_wr_en),
    .host_sel   (host_sel),
    .host_wdata (host_wdata),
    .done       (done),
    .rdata      (rdata),
    .cmd        (cmd),
    .start_cmd  (start_cmd),
    .busy       (busy),
    .data       (data),
    .start      (start)
  );

  mdio_clk_gen #(.CLK_DIV(CLK_DIV)) u_clk (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .run       (active),
    .mdc       (mdc),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick)
  );

  mdio_frame_eng u_eng (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .start     (start),
    .cmd       (start_cmd),
    .wdata     (data),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick),
    .mdio_i    (mdio_i),
    .active    (active),
    .done      (done),
    .rdata     (rdata),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe)
  );

  assign acc_rdata  = {16'h0000, cmd.phy, cmd.idx, 4'h0, cmd.wr, busy};
  assign data_rdata = {16'h0000, data};
endmodule

// File: rtl/mdio_mgmt_ctrl_chk.sv
module mdio_mgmt_ctrl_chk #(
  parameter int CLK_DIV = 20
) (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] acc_rdata,
  input logic [31:0] data_rdata,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe
);
  localparam int HALF = CLK_DIV / 2;
  logic [15:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   hi_cnt <= '0;
    else if (mdc) hi_cnt <= hi_cnt + 1'b1;
    else          hi_cnt <= '0;
  end

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_rdata[31:16] == 16'h0) && (acc_rdata[5:2] == 4'h0) && (data_rdata[31:16] == 16'h0)); // R2
  AST_CMD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_rdata[0] && $past(acc_rdata[0])) |-> $stable(acc_rdata[15:1])); // R4
  AST_WR_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_rdata[0] && acc_rdata[1] && $past(acc_rdata[0])) |-> $stable(data_rdata)); // R4
  AST_MDC_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_rdata[0] |-> !mdc); // R7
  AST_MDIO_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(mdio_o) || !$stable(mdio_oe)) |-> !mdc); // R7
  AST_MDC_HIGH_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mdc) |-> (hi_cnt == 16'(HALF))); // R7
  AST_OE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    mdio_oe |-> acc_rdata[0]); // R8
endmodule

bind mdio_mgmt_ctrl mdio_mgmt_ctrl_chk #(.CLK_DIV(CLK_DIV)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .acc_rdata  (acc_rdata),
  .data_rdata (data_rdata),
  .mdc        (mdc),
  .mdio_o     (mdio_o),
  .mdio_oe    (mdio_oe)
);

// File: tb/mdio_mgmt_ctrl_tb.sv
`timescale 1ns/1ps
module mdio_mgmt_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 4;

  logic        clk, rst_n, host_wr_en, host_sel;
  logic [31:0] host_wdata, acc_rdata, data_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        phy_oe, phy_val;
  wire         mdio_bus = mdio_oe ? mdio_o : (phy_oe ? phy_val : 1'b1);

  int tests = 0, fails = 0, cycles = 0, rise_idx = 0, per_err = 0;
  time last_rise = 0;
  logic [63:0] cap_vec, cap_oe;
  logic [15:0] mem [32];

  mdio_mgmt_ctrl #(.CLK_DIV(DIV)) u_dut (
    .clk(clk), .rst_n(rst_n), .host_wr_en(host_wr_en), .host_sel(host_sel),
    .host_wdata(host_wdata), .acc_rdata(acc_rdata), .data_rdata(data_rdata),
    .mdc(mdc), .mdio_i(mdio_bus), .mdio_o(mdio_o), .mdio_oe(mdio_oe));

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog expired act=%0d exp<=150000", cycles);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  // bench PHY model at address 1
  always @(posedge mdc) begin
    if (rise_idx > 0 && rise_idx < 64 && ($time - last_rise) != DIV * CLK_PERIOD) per_err++;
    last_rise = $time;
    if (rise_idx < 64) begin
      cap_vec[63 - rise_idx] = mdio_bus;
      cap_oe[63 - rise_idx]  = mdio_oe;
    end
    rise_idx++;
    if (rise_idx == 64 && cap_vec[29:28] == 2'b01 && cap_vec[27:23] == 5'd1)
      mem[cap_vec[22:18]] = cap_vec[15:0];
  end

  always @(negedge mdc) begin
    if (cap_vec[29:28] == 2'b10 && cap_vec[27:23] == 5'd1 && rise_idx >= 47 && rise_idx <= 63) begin
      phy_oe  = 1'b1;
      phy_val = (rise_idx == 47) ? 1'b0 : mem[cap_vec[22:18]][63 - rise_idx];
    end else begin
      phy_oe = 1'b0;
    end
  end

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic host_wr(input logic sel, input logic [31:0] d);
    @(negedge clk);
    host_wr_en = 1'b1; host_sel = sel; host_wdata = d;
    @(negedge clk);
    host_wr_en = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 2000 && acc_rdata[0]; i++) @(negedge clk);
  endtask

  function automatic logic [15:0] wval(input int r);
    return 16'hA5C3 ^ 16'(r * 16'h0913);
  endfunction

  task automatic txn(input logic [4:0] phy, input logic [4:0] rg, input logic wr,
                     input logic [15:0] d, input logic [15:0] exp_rd);
    if (wr) host_wr(1'b1, {16'h0, d});
    rise_idx = 0;
    host_wr(1'b0, {16'h0, phy, rg, 4'h0, wr, 1'b1});
    chk("R3", "busy after start", 64'(acc_rdata[0]), 64'd1);
    wait_idle();
    repeat (3 * DIV) @(negedge clk);
    chk("R3", "one frame of 64 rises", 64'(rise_idx), 64'd64);
    chk("R8", "idle mdc/oe", {62'h0, mdc, mdio_oe}, 64'h0);
    if (wr) begin
      chk("R5", "write frame", cap_vec, {32'hFFFF_FFFF, 2'b01, 2'b01, phy, rg, 2'b10, d});
      chk("R5", "write oe", cap_oe, {64{1'b1}});
    end else begin
      chk("R6", "read header", 64'(cap_vec[63:18]), 64'({32'hFFFF_FFFF, 2'b01, 2'b10, phy, rg}));
      chk("R6", "read oe", cap_oe, {{46{1'b1}}, 18'h0});
      chk("R6", "read data", 64'(data_rdata), 64'(exp_rd));
    end
  endtask

  initial begin
    host_wr_en = 0; host_sel = 0; host_wdata = 0; phy_oe = 0; phy_val = 0;
    cap_vec = '0; cap_oe = '0;
    for (int i = 0; i < 32; i++) mem[i] = {5'(i), ~5'(i), 6'h2A};
    rst_n = 0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1", "acc reset", 64'(acc_rdata), 64'h0);
    chk("R1", "data reset", 64'(data_rdata), 64'h0);
    chk("R1", "mdc/oe reset", {62'h0, mdc, mdio_oe}, 64'h0);

    // R2 field layout, reserved bits zero; R3 no start without bit 0
    rise_idx = 0;
    host_wr(1'b1, 32'hFFFF_FFFF);
    chk("R2", "data readback", 64'(data_rdata), 64'h0000_FFFF);
    host_wr(1'b0, 32'hFFFF_FFFE);
    chk("R2", "acc readback", 64'(acc_rdata), 64'h0000_FFC2);
    host_wr(1'b0, {16'h0, 5'd9, 5'd22, 4'hF, 1'b0, 1'b0});
    chk("R2", "acc fields", 64'(acc_rdata), 64'({16'h0, 5'd9, 5'd22, 4'h0, 2'b00}));
    repeat (4 * DIV) @(negedge clk);
    chk("R3", "no frame without busy bit", {31'h0, mdc, 32'(rise_idx)}, 64'h0);

    // R6 reads of power-on contents at PHY 1
    for (int r = 0; r < 4; r++) txn(5'd1, 5'(r), 1'b0, 16'h0, {5'(r), ~5'(r), 6'h2A});
    // R5 write sweep then R6 read-back sweep
    for (int r = 0; r < 32; r++) txn(5'd1, 5'(r), 1'b1, wval(r), 16'h0);
    for (int r = 0; r < 32; r++) txn(5'd1, 5'(r), 1'b0, 16'h0, wval(r));
    // R6 absent PHY reads pull-up
    txn(5'd0, 5'd3, 1'b0, 16'h0, 16'hFFFF);
    txn(5'd31, 5'd17, 1'b0, 16'h0, 16'hFFFF);
    txn(5'd2, 5'd0, 1'b1, 16'h1234, 16'h0);

    // R4 writes during busy ignored (write frame)
    rise_idx = 0;
    host_wr(1'b1, 32'h0000_5A5A);
    host_wr(1'b0, {16'h0, 5'd1, 5'd7, 4'h0, 2'b11});
    host_wr(1'b1, 32'h0000_0F0F);
    host_wr(1'b0, {16'h0, 5'd30, 5'd30, 4'h0, 2'b01});
    wait_idle();
    repeat (3 * DIV) @(negedge clk);
    chk("R4", "data held during write", 64'(data_rdata), 64'h5A5A);
    chk("R4", "cmd held", 64'(acc_rdata), 64'({16'h0, 5'd1, 5'd7, 4'h0, 2'b10}));
    chk("R4", "single frame", 64'(rise_idx), 64'd64);
    chk("R4", "frame data", 64'(cap_vec[15:0]), 64'h5A5A);
    // R4 during read: data write dropped, PHY value returned
    rise_idx = 0;
    host_wr(1'b0, {16'h0, 5'd1, 5'd7, 4'h0, 2'b01});
    host_wr(1'b1, 32'h0000_1111);
    wait_idle();
    repeat (3 * DIV) @(negedge clk);
    chk("R4", "read data not overwritten", 64'(data_rdata), 64'h5A5A);
    chk("R7", "mdc period", 64'(per_err), 64'h0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule